// File: doc/BRIEF.md
# Keyboard Matrix Scanner with Key Queue

This block drives the scan lines of a key matrix one row at a time, reads the column return lines, and debounces each closure. A key is accepted only when it is seen closed on two consecutive scan passes. Each accepted key becomes an 8-bit code that also carries the SHIFT and CTRL input levels. Codes wait in an eight-entry first-in-first-out queue until a host reads them.

The host reaches the block through a small register port. It has a chip select, an address bit that picks data or control/status, one-cycle read and write strobes and an 8-bit data bus. An interrupt output tells the host that there is work to do. The port has no back-pressure: each strobe cycle is one complete access, and read data is presented on the cycle after the strobe.

A configuration write selects one of two scan output forms:
- a binary row number, decoded outside the block;
- a one-hot pattern on four lines.

A sensor mode turns the row storage into a live image of the matrix. In this mode the interrupt is raised whenever any sensor changes state.

Top module: `kbd_scan_fifo`

## Requirements
- R1: In encoded mode (config bit 0 = 0), scan_o carries the binary row number, zero-extended, counting 0..ROWS-1 and wrapping. Each row is held for TICK_CYC clock cycles, and the count restarts at row 0 on the edge of a configuration write.
- R2: In decoded mode (config bit 0 = 1), scan_o is one-hot, with bit n set for row n, and only rows 0..3 are scanned. Keys in those rows are still accepted and coded.
- R3: A closure is accepted only after it has been sampled closed on two consecutive passes of its row. A closure seen on a single pass produces no entry.
- R4: The code format is bit 7 = CTRL, bit 6 = SHIFT, bits 5:3 = row and bits 2:0 = column. SHIFT and CTRL are sampled when the code is stored.
- R5: Codes are read back in acceptance order, and the queue holds up to 8 codes. When several new keys in one row confirm on the same pass, the lowest column is stored first, one key per pass.
- R6: A key that stays closed produces exactly one entry. After it is released, a new closure produces a new entry.
- R7: In key mode, irq_o is high while the queue holds codes and low while it is empty. On the cycle after each data read strobe irq_o is low, and it goes high again on the next cycle if codes remain.
- R8: A data read (A0 = 0) on an empty queue returns the last code read and sets the underrun status bit, bit 7.
- R9: A code accepted while the queue is full is dropped and sets the overrun status bit, bit 6. A status read (A0 = 1) returns underrun in bit 7, overrun in bit 6 and the entry count in bits 3:0, then clears both sticky bits.
- R10: In sensor mode (config bit 1 = 1), no codes are queued. Data reads return the raw row status of rows 0, 1, 2 and onward in turn. irq_o rises after any row changes and is cleared by a data read.
- R11: After reset, the block is in encoded key mode with scan_o = 0, irq_o = 0 and status 0x00. A configuration write (A0 = 1 with the write strobe) sets the mode bits and empties the queue, the debounce state and the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_o | output | 4 | Scan lines: binary row number or one-hot row |
| ret_i | input | COLS | Return lines of the active row, 1 = closed |
| shift_i | input | 1 | SHIFT key level |
| ctrl_i | input | 1 | CTRL key level |
| cs_i | input | 1 | Chip select for the host port |
| a0_i | input | 1 | 0 = data, 1 = control on write / status on read |
| rd_i | input | 1 | Read strobe, one access per cycle high |
| wr_i | input | 1 | Write strobe, one access per cycle high |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a closure that is sampled on exactly one pass. To build it, the bench waits until the scan output first shows the target row, closes the key, and opens it again as soon as the scan moves on, so that exactly one sample sees it. The overrun case is reached by confirming nine distinct keys one after another without reading. The lowest-column ordering is reached by closing two columns of one row in the same cycle.

// File: rtl/kbs_pkg.sv
package kbs_pkg;
  localparam int SL_W = 4;

  typedef struct packed {
    logic       ctrl;
    logic       shift;
    logic [2:0] row;
    logic [2:0] col;
  } key_code_t;

  typedef struct packed {
    logic       under;
    logic       over;
    logic [1:0] rsvd;
    logic [3:0] count;
  } status_t;

  function automatic logic [SL_W-1:0] row_onehot(input logic [1:0] idx);
    return SL_W'(1) << idx;
  endfunction
endpackage

// File: rtl/kbs_scan_timer.sv
module kbs_scan_timer
  import kbs_pkg::*;
#(
  parameter int ROWS     = 8,
  parameter int TICK_CYC = 1000,
  localparam int ROW_W   = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             decoded_i,
  output logic             tick_o,
  output logic [ROW_W-1:0] row_o,
  output logic [SL_W-1:0]  scan_o
);
  logic [ROW_W-1:0] row_q;
  logic [ROW_W-1:0] last_row;

  generate
    if (TICK_CYC > 1) begin : g_div
      localparam int DIV_W = $clog2(TICK_CYC);
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_CYC - 1);
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk) begin
        if (!rst_n || restart_i) div_q <= '0;
        else if (div_q == DIV_LAST) div_q <= '0;
        else div_q <= div_q + 1'b1;
      end
      assign tick_o = (div_q == DIV_LAST);
    end else begin : g_nodiv
      assign tick_o = 1'b1;
    end
  endgenerate

  assign last_row = decoded_i ? ROW_W'(3) : ROW_W'(ROWS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || restart_i) row_q <= '0;
    else if (tick_o) row_q <= (row_q == last_row) ? '0 : row_q + 1'b1;
  end

  assign row_o  = row_q;
  assign scan_o = decoded_i ? row_onehot(row_q[1:0]) : SL_W'(row_q);
endmodule

// File: rtl/kbs_debounce.sv
module kbs_debounce #(
  parameter int ROWS   = 8,
  parameter int COLS   = 8,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COLS-1:0]  ret_i,
  input  logic             sensor_i,
  input  logic [ROW_W-1:0] rd_row_i,
  output logic             push_o,
  output logic [COL_W-1:0] push_col_o,
  output logic             change_o,
  output logic [COLS-1:0]  rd_status_o
);
  logic [COLS-1:0] prev_q [ROWS];
  logic [COLS-1:0] held_q [ROWS];
  logic [COLS-1:0] cur_prev, cur_held, fresh, pick_mask;

  assign cur_prev  = prev_q[row_i];
  assign cur_held  = held_q[row_i];
  // closed now, closed on the previous pass, and not yet reported
  assign fresh     = ret_i & cur_prev & ~cur_held;
  assign pick_mask = fresh & (~fresh + COLS'(1));

  always_comb begin
    push_col_o = '0;
    for (int c = COLS - 1; c >= 0; c--) begin
      if (fresh[c]) push_col_o = COL_W'(c);
    end
  end

  assign push_o      = tick_i && !sensor_i && (|fresh);
  assign change_o    = tick_i && sensor_i && (ret_i != cur_prev);
  assign rd_status_o = prev_q[rd_row_i];

  always_ff @(posedge clk) begin
    if (!rst_n || restart_i) begin
      for (int r = 0; r < ROWS; r++) begin
        prev_q[r] <= '0;
        held_q[r] <= '0;
      end
    end else if (tick_i) begin
      prev_q[row_i] <= ret_i;
      held_q[row_i] <= (cur_held & ret_i) | (sensor_i ? '0 : pick_mask);
    end
  end
endmodule

// File: rtl/kbs_fifo.sv
module kbs_fifo #(
  parameter int DEPTH  = 8,
  parameter int W      = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wptr_q <= bump(wptr_q);
      if (pop_ok)  rptr_q <= bump(rptr_q);
      cnt_q <= cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  assign head_o  = mem_q[rptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/kbd_scan_fifo.sv
module kbd_scan_fifo
  import kbs_pkg::*;
#(
  parameter int ROWS     = 8,
  parameter int COLS     = 8,
  parameter int DEPTH    = 8,
  parameter int TICK_CYC = 1000
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [3:0]      scan_o,
  input  logic [COLS-1:0] ret_i,
  input  logic            shift_i,
  input  logic            ctrl_i,
  input  logic            cs_i,
  input  logic            a0_i,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic [7:0]      wdata_i,
  output logic [7:0]      rdata_o,
  output logic            irq_o
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             cfg_wr, data_rd, stat_rd;
  logic             cfg_dec_q, cfg_sens_q;
  logic             tick, push, change;
  logic [ROW_W-1:0] row, srow_q;
  logic [COL_W-1:0] push_col;
  logic [COLS-1:0]  rd_status;
  logic [7:0]       head, last_q, rdata_q;
  logic [CNT_W-1:0] fifo_cnt, cnt_next;
  logic             fifo_full, fifo_empty, pop_ok, push_ok;
  logic             over_q, under_q, sens_q, sens_d, irq_q;
  key_code_t        code_w;
  status_t          st_w;

  assign cfg_wr  = cs_i && wr_i && a0_i;
  assign data_rd = cs_i && rd_i && !a0_i;
  assign stat_rd = cs_i && rd_i && a0_i;

  kbs_scan_timer #(.ROWS(ROWS), .TICK_CYC(TICK_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart_i(cfg_wr), .decoded_i(cfg_dec_q),
    .tick_o(tick), .row_o(row), .scan_o(scan_o)
  );

  kbs_debounce #(.ROWS(ROWS), .COLS(COLS)) u_deb (
    .clk(clk), .rst_n(rst_n), .restart_i(cfg_wr), .tick_i(tick), .row_i(row),
    .ret_i(ret_i), .sensor_i(cfg_sens_q), .rd_row_i(srow_q),
    .push_o(push), .push_col_o(push_col), .change_o(change),
    .rd_status_o(rd_status)
  );

  assign code_w = '{ctrl: ctrl_i, shift: shift_i, row: 3'(row), col: 3'(push_col)};

  assign pop_ok  = data_rd && !cfg_sens_q && !fifo_empty;
  assign push_ok = push && !fifo_full;

  kbs_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush_i(cfg_wr), .push_i(push), .wdata_i(code_w),
    .pop_i(pop_ok), .head_o(head), .count_o(fifo_cnt), .full_o(fifo_full),
    .empty_o(fifo_empty)
  );

  assign cnt_next = fifo_cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
  assign sens_d   = change ? 1'b1 : (data_rd ? 1'b0 : sens_q);
  assign st_w     = '{under: under_q, over: over_q, rsvd: 2'b00, count: 4'(fifo_cnt)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_dec_q  <= 1'b0;
      cfg_sens_q <= 1'b0;
      srow_q     <= '0;
      over_q     <= 1'b0;
      under_q    <= 1'b0;
      sens_q     <= 1'b0;
      irq_q      <= 1'b0;
      rdata_q    <= '0;
      last_q     <= '0;
    end else if (cfg_wr) begin
      cfg_dec_q  <= wdata_i[0];
      cfg_sens_q <= wdata_i[1];
      srow_q     <= '0;
      over_q     <= 1'b0;
      under_q    <= 1'b0;
      sens_q     <= 1'b0;
      irq_q      <= 1'b0;
      last_q     <= '0;
    end else begin
      if (stat_rd) begin
        over_q  <= 1'b0;
        under_q <= 1'b0;
        rdata_q <= st_w;
      end
      if (push && fifo_full) over_q <= 1'b1;
      if (data_rd) begin
        if (cfg_sens_q) begin
          rdata_q <= 8'(rd_status);
          srow_q  <= (srow_q == ROW_W'(ROWS - 1)) ? '0 : srow_q + 1'b1;
        end else if (!fifo_empty) begin
          rdata_q <= head;
          last_q  <= head;
        end else begin
          rdata_q <= last_q;
          under_q <= 1'b1;
        end
      end
      sens_q <= sens_d;
      irq_q  <= cfg_sens_q ? sens_d : ((cnt_next != '0) && !data_rd);
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/kbs_checker.sv
module kbs_checker #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       scan_o,
  input logic             irq_o,
  input logic             cfg_dec,
  input logic             cfg_sens,
  input logic             tick,
  input logic             cfg_wr,
  input logic             data_rd,
  input logic [CNT_W-1:0] count,
  input logic             push,
  input logic             full,
  input logic             over_flag
);
  p_scan_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cfg_wr) |=> $stable(scan_o));

  p_decoded_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_dec |-> ($countones(scan_o) == 1));

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  p_irq_drop_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !cfg_sens) |=> !irq_o);

  p_irq_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_sens && count == '0) |-> !irq_o);

  p_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !cfg_wr) |=> over_flag);

  p_no_push_sensor_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sens |-> !push);
endmodule

bind kbd_scan_fifo kbs_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scan_o(scan_o), .irq_o(irq_o), .cfg_dec(cfg_dec_q),
  .cfg_sens(cfg_sens_q), .tick(tick), .cfg_wr(cfg_wr), .data_rd(data_rd),
  .count(fifo_cnt), .push(push), .full(fifo_full), .over_flag(over_q)
);

// File: tb/sim_kbd_scan_fifo.sv
`timescale 1ns/1ps
module sim_kbd_scan_fifo;
  localparam int TICK = 4;
  localparam int PASS = 8 * TICK;

  // {row[2:0], col[2:0], shift, ctrl, expected code}
  localparam logic [15:0] VEC [6] = '{
    {3'd0, 3'd0, 1'b0, 1'b0, 8'h00},
    {3'd7, 3'd7, 1'b0, 1'b0, 8'h3F},
    {3'd2, 3'd5, 1'b1, 1'b0, 8'h55},
    {3'd5, 3'd1, 1'b0, 1'b1, 8'hA9},
    {3'd3, 3'd6, 1'b1, 1'b1, 8'hDE},
    {3'd4, 3'd2, 1'b0, 1'b0, 8'h22}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] scan_o;
  logic [7:0] ret;
  logic       shift_i = 1'b0, ctrl_i = 1'b0;
  logic       cs = 1'b0, a0 = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata_o;
  logic       irq_o;
  logic [7:0] keys [8];
  logic       dec_mode = 1'b0;
  logic [2:0] row_sel;
  int         nchk = 0, nerr = 0;
  logic [7:0] d;

  always #4 clk = ~clk;

  kbd_scan_fifo #(.ROWS(8), .COLS(8), .DEPTH(8), .TICK_CYC(TICK)) u0 (
    .clk(clk), .rst_n(rst_n), .scan_o(scan_o), .ret_i(ret), .shift_i(shift_i),
    .ctrl_i(ctrl_i), .cs_i(cs), .a0_i(a0), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always_comb begin
    row_sel = '0;
    if (dec_mode) begin
      for (int i = 0; i < 4; i++) if (scan_o[i]) row_sel = 3'(i);
    end else begin
      row_sel = scan_o[2:0];
    end
    ret = keys[row_sel];
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  task automatic host_write(input logic a, input logic [7:0] v);
    @(negedge clk); cs = 1; wr = 1; a0 = a; wdata = v;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic host_read(input logic a, output logic [7:0] v);
    @(negedge clk); cs = 1; rd = 1; a0 = a;
    @(negedge clk); cs = 0; rd = 0; v = rdata_o;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_keys();
    for (int i = 0; i < 8; i++) keys[i] = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    clear_keys();
    repeat (5) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    chk("R11 scan", {4'h0, scan_o}, 8'h00);
    chk("R11 irq", {7'b0, irq_o}, 8'h00);
    host_read(1, d); chk("R11 status", d, 8'h00);

    // R1 encoded scan sequence and dwell
    host_write(1, 8'h00);
    for (int k = 0; k < 2 * PASS; k++) begin
      chk("R1 scan", {4'h0, scan_o}, 8'((k / TICK) % 8));
      @(negedge clk);
    end

    // R4 code format, table driven
    for (int v = 0; v < 6; v++) begin
      shift_i = VEC[v][9]; ctrl_i = VEC[v][8];
      keys[VEC[v][15:13]][VEC[v][12:10]] = 1'b1;
      wait_cyc(3 * PASS);
      keys[VEC[v][15:13]][VEC[v][12:10]] = 1'b0;
      wait_cyc(PASS);
      host_read(0, d); chk("R4 code", d, VEC[v][7:0]);
    end
    shift_i = 0; ctrl_i = 0;

    // R3 closure visible on one pass only
    while (scan_o != 4'd5) @(negedge clk);
    keys[5][2] = 1'b1;
    while (scan_o == 4'd5) @(negedge clk);
    keys[5][2] = 1'b0;
    wait_cyc(3 * PASS);
    host_read(1, d); chk("R3 glitch no entry", d, 8'h00);

    // R5 order, R6 held keys, R7 irq
    keys[1][0] = 1; wait_cyc(3 * PASS);
    keys[6][4] = 1; wait_cyc(3 * PASS);
    keys[2][7] = 1; wait_cyc(3 * PASS);
    host_read(1, d); chk("R6 held count", d, 8'h03);
    chk("R7 irq nonempty", {7'b0, irq_o}, 8'h01);
    host_read(0, d); chk("R5 first", d, 8'h08);
    chk("R7 irq low after read", {7'b0, irq_o}, 8'h00);
    @(negedge clk); chk("R7 irq back", {7'b0, irq_o}, 8'h01);
    host_read(0, d); chk("R5 second", d, 8'h34);
    host_read(0, d); chk("R5 third", d, 8'h17);
    chk("R7 irq empty", {7'b0, irq_o}, 8'h00);
    @(negedge clk); chk("R7 irq stays low", {7'b0, irq_o}, 8'h00);
    keys[1][0] = 0; wait_cyc(2 * PASS);
    keys[1][0] = 1; wait_cyc(3 * PASS);
    host_read(1, d); chk("R6 re-press count", d, 8'h01);
    host_read(0, d); chk("R6 re-press code", d, 8'h08);
    clear_keys(); wait_cyc(PASS);

    // R5 two columns of one row together
    keys[1] = 8'b0100_0100; wait_cyc(4 * PASS);
    host_read(0, d); chk("R5 low column first", d, 8'h0A);
    host_read(0, d); chk("R5 high column next", d, 8'h0E);
    clear_keys(); wait_cyc(PASS);

    // R9 overrun, R8 underrun
    for (int k = 0; k < 9; k++) begin
      keys[k % 8][k / 8] = 1; wait_cyc(3 * PASS);
      keys[k % 8][k / 8] = 0; wait_cyc(PASS);
    end
    host_read(1, d); chk("R9 overrun status", d, 8'h48);
    host_read(1, d); chk("R9 status cleared", d, 8'h08);
    for (int k = 0; k < 8; k++) begin
      host_read(0, d); chk("R5 full order", d, 8'(k << 3));
    end
    host_read(0, d); chk("R8 empty read value", d, 8'h38);
    host_read(1, d); chk("R8 underrun status", d, 8'h80);

    // R11 configuration write empties the queue
    keys[4][4] = 1; wait_cyc(3 * PASS);
    keys[4][4] = 0; wait_cyc(PASS);
    host_read(1, d); chk("R11 before config", d, 8'h01);
    dec_mode = 1;
    host_write(1, 8'h01);
    host_read(1, d); chk("R11 config clears", d, 8'h00);

    // R2 decoded scan
    host_write(1, 8'h01);
    for (int k = 0; k < 8 * TICK; k++) begin
      chk("R2 onehot", {4'h0, scan_o}, 8'(1 << ((k / TICK) % 4)));
      @(negedge clk);
    end
    keys[2][3] = 1; wait_cyc(2 * PASS);
    keys[2][3] = 0; wait_cyc(PASS);
    host_read(0, d); chk("R2 decoded key", d, 8'h13);

    // R10 sensor mode
    dec_mode = 0;
    clear_keys();
    host_write(1, 8'h02);
    keys[3] = 8'hA5; wait_cyc(2 * PASS);
    chk("R10 irq on change", {7'b0, irq_o}, 8'h01);
    for (int r = 0; r < 8; r++) begin
      host_read(0, d); chk("R10 row status", d, (r == 3) ? 8'hA5 : 8'h00);
    end
    chk("R10 irq cleared", {7'b0, irq_o}, 8'h00);
    host_read(1, d); chk("R10 no queued codes", d, 8'h00);
    keys[6] = 8'h3C; wait_cyc(2 * PASS);
    chk("R10 irq second change", {7'b0, irq_o}, 8'h01);

    finish_run();
  end
endmodule